// File: doc/BRIEF.md
# Double-Buffered Converter Code Register

This block is the digital front end of a 16-bit parallel-input digital-to-analog converter. It turns the converter's control pins into updates of two registers and drives the resulting output code. A host writes a word into a staging (input) register and can read that word back over the same bus before it commits. A separate load strobe then moves the staged word into the output (DAC) register, which drives the code toward the analog ladder. The load strobe can be shared by several converters so that their outputs change together.

All pins are sampled on one clock. A chip-select rise commits the last word seen while the part was selected for writing. Holding the load strobe low makes the output register follow the staging register on every clock. With select, write and load all low at once, the bus word goes straight to the output. A low reset level overrides everything and forces both registers to one of two preset codes. The codes are complementary: all-ones is the lowest output and 7FFF hex is bipolar zero. The bidirectional bus is split into an input, an output and a drive enable, so the pad ring can build the tri-state buffer.

Top module: `dbuf_dac_ctrl`

## Requirements
- R1: While rst_n is low, dac_code and the readback word equal 7FFF hex when rsel is 1 and FFFF hex when rsel is 0. They follow any change of rsel at once, without waiting for a clock, and ignore every other input.
- R2: When rst_n rises, both registers keep the preset that was selected at the release. A later change of rsel has no effect.
- R3: The word on bus_in in the last clocked cycle with cs_n=0 and rw=0 enters the input register at the first clock where cs_n is sampled high again. While ld_n is 1, dac_code does not change.
- R4: On a clock where ld_n=0 and no read or pass-through applies, the DAC register takes the input register's value, including a word committed at that same clock. dac_code shows it one cycle later.
- R5: On a clock where cs_n=0, rw=0 and ld_n=0, the DAC register takes bus_in directly. dac_code shows it one cycle later.
- R6: While cs_n=0 and rw=1, bus_oe is 1 and bus_out carries the input register. dac_code holds whatever ld_n is.
- R7: While cs_n=1, bus_oe is 0 and bus_out is zero.
- R8: A cs_n rise that ends a read (rw=1 in the last selected cycle) leaves the input register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all control pins |
| rst_n | input | 1 | Asynchronous active-low reset to the preset code |
| rsel | input | 1 | Preset select: 1 gives 7FFF hex, 0 gives FFFF hex |
| cs_n | input | 1 | Active-low select; its rise commits a write |
| rw | input | 1 | 1 = read back, 0 = write |
| ld_n | input | 1 | Active-low level load into the DAC register |
| bus_in | input | 16 | Data bus, inbound half |
| bus_out | output | 16 | Data bus, outbound half (zero when not driven) |
| bus_oe | output | 1 | Drive enable for the outbound bus half |
| dac_code | output | 16 | Code held by the DAC register |

## Verification
The assertions assume the control pins are already synchronous to clk. They also assume that rsel does not change in the clock period in which rst_n rises, because the registers record the preset only at clock edges. The bench drives every input just after a falling edge. It changes rsel only while reset is held, or at least one clock after the release. In the randomized phase a reset is always held for a full clock with rsel steady.

// File: rtl/dbuf_dac_pkg.sv
package dbuf_dac_pkg;

  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_READ = 2'd1,
    CMD_THRU = 2'd2,
    CMD_LOAD = 2'd3
  } dbuf_cmd_e;

  // Priority: readback freezes the output, then pass-through, then level load.
  function automatic dbuf_cmd_e decode_cmd(input logic cs_n, input logic rw,
                                           input logic ld_n);
    dbuf_cmd_e c;
    if (!cs_n && rw)         c = CMD_READ;
    else if (!cs_n && !ld_n) c = CMD_THRU;
    else if (!ld_n)          c = CMD_LOAD;
    else                     c = CMD_HOLD;
    return c;
  endfunction

  // A commit happens on a select rise that follows a write-selected cycle.
  function automatic logic is_commit(input logic was_low, input logic cs_n,
                                     input logic armed);
    return was_low && cs_n && armed;
  endfunction

endpackage

// File: rtl/dbuf_cmd_decode.sv
module dbuf_cmd_decode
  import dbuf_dac_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cs_n,
  input  logic      rw,
  input  logic      ld_n,
  output dbuf_cmd_e cmd,
  output logic      cap_en,
  output logic      commit
);

  logic cs_low_q;
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_low_q <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      cs_low_q <= !cs_n;
      if (!cs_n) armed_q <= !rw;
    end
  end

  always_comb begin
    cmd    = decode_cmd(cs_n, rw, ld_n);
    cap_en = !cs_n && !rw;
    commit = is_commit(cs_low_q, cs_n, armed_q);
  end

endmodule

// File: rtl/dbuf_in_reg.sv
module dbuf_in_reg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] preset,
  input  logic          cap_en,
  input  logic          commit,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] q,
  output logic [DW-1:0] q_nxt
);

  logic [DW-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else if (cap_en) stage_q <= bus_in;
  end

  assign q_nxt = commit ? stage_q : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= preset;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/dbuf_dac_reg.sv
module dbuf_dac_reg
  import dbuf_dac_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] preset,
  input  dbuf_cmd_e     cmd,
  input  logic [DW-1:0] bus_in,
  input  logic [DW-1:0] in_nxt,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= preset;
    end else begin
      unique case (cmd)
        CMD_THRU: q <= bus_in;
        CMD_LOAD: q <= in_nxt;
        default:  q <= q;
      endcase
    end
  end

endmodule

// File: rtl/dbuf_dac_ctrl.sv
module dbuf_dac_ctrl
  import dbuf_dac_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rsel,
  input  logic          cs_n,
  input  logic          rw,
  input  logic          ld_n,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic [DW-1:0] dac_code
);

  localparam logic [DW-1:0] CODE_LOW = {DW{1'b1}};
  localparam logic [DW-1:0] CODE_MID = {1'b0, {(DW-1){1'b1}}};

  logic [DW-1:0] preset;
  logic [DW-1:0] in_reg_q;
  logic [DW-1:0] in_reg_nxt;
  logic [DW-1:0] dac_q;
  logic [DW-1:0] in_word;
  dbuf_cmd_e     cmd;
  logic          cap_en;
  logic          commit;

  assign preset = rsel ? CODE_MID : CODE_LOW;

  dbuf_cmd_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .rw     (rw),
    .ld_n   (ld_n),
    .cmd    (cmd),
    .cap_en (cap_en),
    .commit (commit)
  );

  dbuf_in_reg #(.DW(DW)) u_in (
    .clk    (clk),
    .rst_n  (rst_n),
    .preset (preset),
    .cap_en (cap_en),
    .commit (commit),
    .bus_in (bus_in),
    .q      (in_reg_q),
    .q_nxt  (in_reg_nxt)
  );

  dbuf_dac_reg #(.DW(DW)) u_dac (
    .clk    (clk),
    .rst_n  (rst_n),
    .preset (preset),
    .cmd    (cmd),
    .bus_in (bus_in),
    .in_nxt (in_reg_nxt),
    .q      (dac_q)
  );

  // The reset level overrides the stored values without waiting for a clock.
  assign in_word  = rst_n ? in_reg_q : preset;
  assign dac_code = rst_n ? dac_q : preset;
  assign bus_oe   = !cs_n && rw;
  assign bus_out  = bus_oe ? in_word : '0;

endmodule

// File: rtl/dbuf_dac_ctrl_chk.sv
module dbuf_dac_ctrl_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rsel,
  input logic          cs_n,
  input logic          rw,
  input logic          ld_n,
  input logic [DW-1:0] bus_in,
  input logic [DW-1:0] bus_out,
  input logic          bus_oe,
  input logic [DW-1:0] dac_code,
  input logic [DW-1:0] in_word
);

  logic [DW-1:0] want_preset;
  assign want_preset = {DW{1'b1}} >> rsel;

  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      AST_RST_PRESET: assert (dac_code == want_preset && in_word == want_preset); // R1
    end
  end

  AST_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!bus_oe && bus_out == '0)); // R7

  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && rw) |-> bus_oe); // R6

  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && rw) |=> $stable(dac_code)); // R6

  AST_NO_LOAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n |=> $stable(dac_code)); // R3

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !rw && !ld_n) |=> (dac_code == $past(bus_in))); // R5

  AST_LEVEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !ld_n) |=> (dac_code == in_word)); // R4

  AST_READ_END_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !$past(cs_n) && $past(rw)) |=> $stable(in_word)); // R8

endmodule

bind dbuf_dac_ctrl dbuf_dac_ctrl_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rsel     (rsel),
  .cs_n     (cs_n),
  .rw       (rw),
  .ld_n     (ld_n),
  .bus_in   (bus_in),
  .bus_out  (bus_out),
  .bus_oe   (bus_oe),
  .dac_code (dac_code),
  .in_word  (in_word)
);

// File: tb/sim_dbuf_dac_ctrl.sv
module sim_dbuf_dac_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  logic        clk = 1'b0;
  logic        rst_n, rsel, cs_n, rw, ld_n;
  logic [15:0] bus_in, bus_out, dac_code;
  logic        bus_oe;
  int          total = 0;
  int          bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbuf_dac_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .rsel(rsel), .cs_n(cs_n), .rw(rw), .ld_n(ld_n),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .dac_code(dac_code)
  );

  // Row: [51] cs_n [50] rw [49] ld_n [48:33] bus_in | [32:17] dac [16] oe [15:0] out
  localparam logic [51:0] VEC [NV] = '{
    {3'b001, 16'h1234, 16'h7FFF, 1'b0, 16'h0000},  // stage a word
    {3'b101, 16'hFFFF, 16'h7FFF, 1'b0, 16'h0000},  // commit, output unchanged
    {3'b011, 16'h0000, 16'h7FFF, 1'b1, 16'h1234},  // readback
    {3'b111, 16'hBEEF, 16'h7FFF, 1'b0, 16'h0000},  // R8: rise after a read
    {3'b010, 16'h0000, 16'h7FFF, 1'b1, 16'h1234},  // read with load low
    {3'b100, 16'h0000, 16'h1234, 1'b0, 16'h0000},  // level load
    {3'b101, 16'h5555, 16'h1234, 1'b0, 16'h0000},
    {3'b000, 16'hA5A5, 16'hA5A5, 1'b0, 16'h0000},  // pass-through
    {3'b101, 16'h0000, 16'hA5A5, 1'b0, 16'h0000},  // commit A5A5
    {3'b001, 16'h0000, 16'hA5A5, 1'b0, 16'h0000},
    {3'b100, 16'h9999, 16'h0000, 1'b0, 16'h0000},  // commit and load together
    {3'b011, 16'h0000, 16'h0000, 1'b1, 16'h0000},
    {3'b101, 16'h0000, 16'h0000, 1'b0, 16'h0000},
    {3'b001, 16'h00FF, 16'h0000, 1'b0, 16'h0000},
    {3'b001, 16'h0F0F, 16'h0000, 1'b0, 16'h0000},  // last word wins
    {3'b101, 16'h0000, 16'h0000, 1'b0, 16'h0000},
    {3'b011, 16'h0000, 16'h0000, 1'b1, 16'h0F0F}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  function automatic logic [15:0] ref_preset(input logic s);
    return s ? 16'h7FFF : 16'hFFFF;
  endfunction

  initial begin
    logic [15:0] m_in, m_dac, m_stage, n_in, n_dac;
    logic        m_csp, m_arm, commit;

    rst_n = 1'b0; rsel = 1'b1; cs_n = 1'b1; rw = 1'b1; ld_n = 1'b1; bus_in = '0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 reset code", dac_code, 16'h7FFF);
    chk("R7 idle oe", {15'b0, bus_oe}, 16'h0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {cs_n, rw, ld_n, bus_in} = VEC[i][51:33];
      @(posedge clk);
      #1;
      chk("R3/R4/R5 dac", dac_code, VEC[i][32:17]);
      chk("R6/R7 oe", {15'b0, bus_oe}, {15'b0, VEC[i][16]});
      chk("R6/R7 out", bus_out, VEC[i][15:0]);
    end

    // Reset override and select tracking
    @(negedge clk);
    rst_n = 1'b0; rsel = 1'b1; cs_n = 1'b0; rw = 1'b1;
    #1;
    chk("R1 mid dac", dac_code, 16'h7FFF);
    chk("R1 mid readback", bus_out, 16'h7FFF);
    rsel = 1'b0;
    #1;
    chk("R1 follow dac", dac_code, 16'hFFFF);
    chk("R1 follow readback", bus_out, 16'hFFFF);
    rw = 1'b0; ld_n = 1'b0; bus_in = 16'h1111;
    @(posedge clk);
    #1;
    chk("R1 override", dac_code, 16'hFFFF);
    @(negedge clk);
    cs_n = 1'b1; ld_n = 1'b1; rst_n = 1'b1;
    @(negedge clk) rsel = 1'b1;
    @(posedge clk);
    #1;
    chk("R2 kept dac", dac_code, 16'hFFFF);
    @(negedge clk);
    cs_n = 1'b0; rw = 1'b1;
    #1;
    chk("R2 kept input", bus_out, 16'hFFFF);
    @(negedge clk) cs_n = 1'b1;

    // Randomized sequence against a reference model
    m_in = '0; m_dac = '0; m_stage = '0; m_csp = 1'b1; m_arm = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (k == 0 || ($urandom % 20) == 0) begin
        rst_n = 1'b0;
        rsel  = 1'($urandom % 2);
      end else begin
        rst_n = 1'b1;
      end
      bus_in = 16'($urandom);
      case ($urandom % 6)
        0: begin cs_n = 1'b0; rw = 1'b0; ld_n = 1'b1; end
        1: begin cs_n = 1'b1; rw = 1'($urandom % 2); ld_n = 1'b1; end
        2: begin cs_n = 1'b1; rw = 1'($urandom % 2); ld_n = 1'b0; end
        3: begin cs_n = 1'b0; rw = 1'b0; ld_n = 1'b0; end
        4: begin cs_n = 1'b0; rw = 1'b1; ld_n = 1'($urandom % 2); end
        default: begin cs_n = 1'b1; rw = 1'b0; ld_n = 1'b1; end
      endcase
      if (!rst_n) begin
        n_in = ref_preset(rsel); n_dac = n_in;
        m_csp = 1'b1; m_arm = 1'b0;
      end else begin
        commit = !m_csp && cs_n && m_arm;
        n_in = commit ? m_stage : m_in;
        if (!cs_n && rw)                n_dac = m_dac;
        else if (!cs_n && !rw && !ld_n) n_dac = bus_in;
        else if (!ld_n)                 n_dac = n_in;
        else                            n_dac = m_dac;
        if (!cs_n) begin
          m_arm = !rw;
          if (!rw) m_stage = bus_in;
        end
        m_csp = cs_n;
      end
      @(posedge clk);
      #1;
      m_in = n_in; m_dac = n_dac;
      chk("R3/R4/R5/R6 random dac", dac_code, m_dac);
      if (!cs_n && rw) chk("R6/R8 random readback", bus_out, m_in);
      else             chk("R7 random idle bus", bus_out, 16'h0000);
    end

    summary();
  end

endmodule